// File: doc/BRIEF.md
# Supply-Aware Memory Access Gate

This block stands between a memory controller and an external non-volatile memory. The controller issues active-low enable and write requests. The gate passes them to the memory only while both supplies, the core supply and the I/O supply, are reported good. They must also have stayed good for a full startup interval. At all other times both memory control lines are driven high, and no read or write can begin.

The two supply-good flags come from outside and are asynchronous, so each one passes through a two-flop synchroniser before use. A central state machine tracks whether the gate is held off after reset, counting through startup, open for traffic, or held off after a supply dropped during operation. Every recovery restarts the full startup count. This applies to a recovery after a brownout, after a flag dropped in the middle of startup, and after the first power-up. A supply fault during traffic closes the gate at once. If an access was in flight, a one-cycle abort pulse tells the controller to retry it.

The startup length in clock cycles is computed from parameters: the clock frequency in MHz times the startup time in microseconds, plus a guard margin. The default startup time is 2000 µs.

Top module: `pwr_access_gate`

## Requirements
- R1: While reset is asserted, and directly after it is released, memEnN and memWrN are 1, and accessOk and abortPulse are 0.
- R2: While either supply flag is 0, accessOk stays 0 and memEnN and memWrN stay 1, whatever the requests are.
- R3: Both flags are raised before clock edge 1 and stay high. accessOk then goes to 1 at clock edge START_CYCLES+3 and not before. The delay covers two synchroniser stages, one state update and START_CYCLES counted cycles.
- R4: START_CYCLES equals CLK_MHZ times STARTUP_US plus GUARD_CYCLES.
- R5: While accessOk is 1, memEnN equals reqEnN and memWrN equals reqWrN, with no added cycle.
- R6: In the open state, a supply flag can fall before some clock edge, called edge 1. accessOk stays 1 after edge 1. After edge 2, accessOk is 0 and memEnN and memWrN are forced to 1, even while an access is requested.
- R7: abortPulse is 1 for exactly one cycle, after edge 3 of a fault as counted in R6, and only if reqEnN was 0 when the gate closed. A fault with no access requested gives no pulse.
- R8: A supply flag that drops for even one cycle during startup abandons the count. Once the flag returns, the full delay of R3 applies again, counted from its return.
- R9: After a fault in the open state, the gate reopens only after the full delay of R3, counted from the moment both flags are good again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coreGood | input | 1 | Core supply within range (asynchronous) |
| ioGood | input | 1 | I/O supply within range (asynchronous) |
| reqEnN | input | 1 | Active-low enable request from the controller |
| reqWrN | input | 1 | Active-low write request from the controller |
| memEnN | output | 1 | Gated active-low enable to the memory |
| memWrN | output | 1 | Gated active-low write to the memory |
| accessOk | output | 1 | Gate open: accesses are allowed |
| abortPulse | output | 1 | One-cycle pulse: an access was cut off by a supply fault |

## Verification
The gate is exercised with one supply good at a time, to show that neither flag alone opens it. Both flags are then raised together, and the opening edge is checked on the exact cycle. In the open state, random request patterns confirm that requests pass through unchanged. Faults are injected with the bus idle and again with an access in flight. These two cases show the difference between a plain close and a close with an abort. A one-cycle dropout during startup, and a recovery after a brownout, each show that the full interval restarts rather than resuming.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

  typedef enum logic [1:0] {
    ST_INHIBIT  = 2'd0,
    ST_STARTUP  = 2'd1,
    ST_NORMAL   = 2'd2,
    ST_BROWNOUT = 2'd3
  } gateState_e;

  typedef struct packed {
    logic gateOpen;
    logic faultHit;
  } gateStrobe_t;

endpackage

// File: rtl/pwr_gate_sync.sv
module pwr_gate_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/pwr_gate_datapath.sv
module pwr_gate_datapath
  import pwr_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        coreGood,
  input  logic        ioGood,
  input  logic        reqEnN,
  input  logic        reqWrN,
  input  gateStrobe_t strobe,
  output logic        suppliesOk,
  output logic        memEnN,
  output logic        memWrN,
  output logic        accessOk,
  output logic        abortPulse
);

  logic [1:0] flagSync;
  logic       abortQ;

  pwr_gate_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({coreGood, ioGood}),
    .syncOut(flagSync)
  );

  assign suppliesOk = &flagSync;

  // Requests reach the memory only through an open gate; otherwise both lines idle high.
  assign memEnN   = reqEnN | ~strobe.gateOpen;
  assign memWrN   = reqWrN | ~strobe.gateOpen;
  assign accessOk = strobe.gateOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) abortQ <= 1'b0;
    else       abortQ <= strobe.faultHit & ~reqEnN;
  end

  assign abortPulse = abortQ;

endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pwr_gate_pkg::*;
#(
  parameter int START_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        suppliesOk,
  output gateStrobe_t strobe
);

  localparam int TIMER_W = (START_CYCLES > 1) ? $clog2(START_CYCLES + 1) : 1;
  localparam logic [TIMER_W-1:0] LAST_COUNT = TIMER_W'(START_CYCLES - 1);

  gateState_e        stateQ, stateD;
  logic [TIMER_W-1:0] timerQ, timerD;

  always_comb begin
    stateD = stateQ;
    timerD = timerQ;
    unique case (stateQ)
      ST_INHIBIT, ST_BROWNOUT: begin
        timerD = '0;
        if (suppliesOk) stateD = ST_STARTUP;
      end
      ST_STARTUP: begin
        if (!suppliesOk) begin
          stateD = ST_INHIBIT;
          timerD = '0;
        end else if (timerQ == LAST_COUNT) begin
          stateD = ST_NORMAL;
          timerD = '0;
        end else begin
          timerD = timerQ + 1'b1;
        end
      end
      ST_NORMAL: begin
        timerD = '0;
        if (!suppliesOk) stateD = ST_BROWNOUT;
      end
      default: begin
        stateD = ST_INHIBIT;
        timerD = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_INHIBIT;
      timerQ <= '0;
    end else begin
      stateQ <= stateD;
      timerQ <= timerD;
    end
  end

  assign strobe.gateOpen = (stateQ == ST_NORMAL) &  suppliesOk;
  assign strobe.faultHit = (stateQ == ST_NORMAL) & ~suppliesOk;

endmodule

// File: rtl/pwr_access_gate.sv
module pwr_access_gate
  import pwr_gate_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int STARTUP_US   = 2000,
  parameter int GUARD_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic coreGood,
  input  logic ioGood,
  input  logic reqEnN,
  input  logic reqWrN,
  output logic memEnN,
  output logic memWrN,
  output logic accessOk,
  output logic abortPulse
);

  localparam int START_CYCLES = CLK_MHZ * STARTUP_US + GUARD_CYCLES;  // R4
  localparam int SYNC_STAGES  = 2;

  gateStrobe_t strobe;
  logic        suppliesOk;

  pwr_gate_ctrl #(
    .START_CYCLES(START_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .suppliesOk(suppliesOk),
    .strobe    (strobe)
  );

  pwr_gate_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .coreGood  (coreGood),
    .ioGood    (ioGood),
    .reqEnN    (reqEnN),
    .reqWrN    (reqWrN),
    .strobe    (strobe),
    .suppliesOk(suppliesOk),
    .memEnN    (memEnN),
    .memWrN    (memWrN),
    .accessOk  (accessOk),
    .abortPulse(abortPulse)
  );

endmodule

// File: rtl/pwr_access_gate_chk.sv
module pwr_access_gate_chk #(
  parameter int START_CYCLES = 16
) (
  input logic clk,
  input logic rstN,
  input logic coreGood,
  input logic ioGood,
  input logic reqEnN,
  input logic memEnN,
  input logic memWrN,
  input logic accessOk,
  input logic abortPulse
);

  logic [31:0] goodRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         goodRun <= '0;
    else if (!(coreGood && ioGood))    goodRun <= '0;
    else if (goodRun != 32'hFFFF_FFFF) goodRun <= goodRun + 1'b1;
  end

  AST_LINES_HIGH_ON_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(coreGood, 2) || !$past(ioGood, 2)) |-> (memEnN && memWrN && !accessOk)) else $error("supply fault not blocking");  // R2

  AST_OPEN_AFTER_FULL_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accessOk) |-> (goodRun >= 32'(START_CYCLES + 2))) else $error("gate opened early");  // R3

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse) else $error("abort longer than one cycle");  // R7

  AST_ABORT_GATE_SHUT: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (memEnN && memWrN && !accessOk)) else $error("abort while gate open");  // R6

  AST_ABORT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> $past(accessOk, 2)) else $error("abort without prior open gate");  // R7

endmodule

bind pwr_access_gate pwr_access_gate_chk #(
  .START_CYCLES(START_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .coreGood  (coreGood),
  .ioGood    (ioGood),
  .reqEnN    (reqEnN),
  .memEnN    (memEnN),
  .memWrN    (memWrN),
  .accessOk  (accessOk),
  .abortPulse(abortPulse)
);

// File: tb/pwr_access_gate_tb.sv
`timescale 1ns/1ps
module pwr_access_gate_tb;

  localparam int CLK_MHZ      = 1;
  localparam int STARTUP_US   = 20;
  localparam int GUARD_CYCLES = 4;
  localparam int N            = CLK_MHZ * STARTUP_US + GUARD_CYCLES;  // R4: 24

  logic clk = 1'b0;
  logic rstN, coreGood, ioGood, reqEnN, reqWrN;
  logic memEnN, memWrN, accessOk, abortPulse;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pwr_access_gate #(
    .CLK_MHZ     (CLK_MHZ),
    .STARTUP_US  (STARTUP_US),
    .GUARD_CYCLES(GUARD_CYCLES)
  ) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .coreGood  (coreGood),
    .ioGood    (ioGood),
    .reqEnN    (reqEnN),
    .reqWrN    (reqWrN),
    .memEnN    (memEnN),
    .memWrN    (memWrN),
    .accessOk  (accessOk),
    .abortPulse(abortPulse)
  );

  function automatic logic expLine(input logic req, input logic open);
    return req | ~open;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic checkStartup(input string tag);
    tick(N + 2);
    check({tag, " closed one edge before"}, 32'(accessOk), 32'd0);
    tick(1);
    check({tag, " open on edge N+3"}, 32'(accessOk), 32'd1);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    void'($urandom(32'd7741));
    rstN = 1'b0; coreGood = 1'b0; ioGood = 1'b0; reqEnN = 1'b0; reqWrN = 1'b0;
    tick(3);
    check("R1 enable high in reset", 32'(memEnN), 32'd1);
    check("R1 write high in reset", 32'(memWrN), 32'd1);
    check("R1 ok low in reset", 32'(accessOk), 32'd0);
    check("R1 abort low in reset", 32'(abortPulse), 32'd0);
    rstN = 1'b1;
    tick(1);
    check("R1 enable high after release", 32'(memEnN), 32'd1);

    // R2: one supply alone never opens the gate
    coreGood = 1'b1;
    tick(N + 10);
    check("R2 core only ok", 32'(accessOk), 32'd0);
    check("R2 core only enable", 32'(memEnN), 32'd1);
    check("R2 core only write", 32'(memWrN), 32'd1);
    coreGood = 1'b0; ioGood = 1'b1;
    tick(N + 10);
    check("R2 io only ok", 32'(accessOk), 32'd0);
    check("R2 io only enable", 32'(memEnN), 32'd1);
    ioGood = 1'b0;
    tick(4);

    // R3: exact opening edge
    reqEnN = 1'b1; reqWrN = 1'b1;
    coreGood = 1'b1; ioGood = 1'b1;
    checkStartup("R3 first power-up");

    // R5: random request patterns pass straight through
    for (int i = 0; i < 40; i++) begin
      reqEnN = 1'($urandom);
      reqWrN = 1'($urandom);
      #1;
      check("R5 enable pass", 32'(memEnN), 32'(expLine(reqEnN, 1'b1)));
      check("R5 write pass", 32'(memWrN), 32'(expLine(reqWrN, 1'b1)));
      tick(1);
    end

    // R6/R7: fault with the bus idle
    reqEnN = 1'b1; reqWrN = 1'b1;
    ioGood = 1'b0;
    tick(1);
    check("R6 still open after edge 1", 32'(accessOk), 32'd1);
    tick(1);
    check("R6 closed after edge 2", 32'(accessOk), 32'd0);
    tick(1);
    check("R7 no abort when idle", 32'(abortPulse), 32'd0);
    tick(3);
    ioGood = 1'b1;
    checkStartup("R9 recovery after idle fault");

    // R6/R7: fault during an active write
    reqEnN = 1'b0; reqWrN = 1'b0;
    #1;
    check("R5 active write enable", 32'(memEnN), 32'd0);
    coreGood = 1'b0;
    tick(1);
    check("R6 write passes before edge 2", 32'(memWrN), 32'd0);
    tick(1);
    check("R6 enable forced high", 32'(memEnN), 32'd1);
    check("R6 write forced high", 32'(memWrN), 32'd1);
    check("R7 no abort yet", 32'(abortPulse), 32'd0);
    tick(1);
    check("R7 abort pulse", 32'(abortPulse), 32'd1);
    tick(1);
    check("R7 abort one cycle", 32'(abortPulse), 32'd0);
    check("R2 requests held off", 32'(memEnN), 32'd1);

    // R9 after brownout, then R8 dropout in the middle of startup
    coreGood = 1'b1;
    tick(10);
    check("R9 still counting", 32'(accessOk), 32'd0);
    coreGood = 1'b0;
    tick(1);
    coreGood = 1'b1;
    checkStartup("R8 restart after dropout");
    #1;
    check("R5 pass after restart", 32'(memEnN), 32'(expLine(reqEnN, 1'b1)));

    finishRun();
  end

endmodule